// File: doc/BRIEF.md
# Windowed Byte Register Bridge

This block lets a host that only speaks 32-bit control words reach a bank of 8-bit registers that are slow to access. One 32-bit window word carries the command and the result. The host writes an 8-bit target address, an 8-bit payload and an operation bit in that word. It then polls a busy flag until the internal access has finished. For a read, it finally picks up the returned byte from the top of the same word.

Every accepted host write starts exactly one internal access. That access takes a fixed, parameterised number of cycles. Commands that arrive while an access is running are dropped. The register bank sits inside the block, so the bridge can be exercised on its own. The bank is sized by a parameter, and addresses beyond its end behave as empty locations.

Top module: `winbr_bridge`

## Requirements
- R1: After reset the window word reads back as all zeros, and every bank register holds zero.
- R2: After an accepted host write, the window word reads back the accepted address in bits [7:0], the payload in bits [15:8], and the operation bit in bit 16 (1 = write, 0 = read).
- R3: The busy flag in bit 23 is set in the cycle after the clock edge at which a host write is accepted.
- R4: The busy flag stays set for exactly LATENCY clock cycles for each accepted access.
- R5: For a read access, the read-data field in bits [31:24] keeps its old value while busy is set. It takes the addressed bank byte in the same cycle that busy clears.
- R6: A write access stores the payload in the addressed bank register, and a later read of that address returns it.
- R7: A host write that arrives while busy is set is ignored. The latched fields do not change, the running access finishes on time with its original command, and the dropped command does not reach the bank.
- R8: Bits [22:17] of the window word always read as zero, whatever the host writes into them.
- R9: A write access leaves the read-data field unchanged.
- R10: An address at or above BANK_DEPTH discards writes and reads back zero.
- R11: A read of a bank register that has never been written returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bridge and the bank |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe for the window word |
| host_wdata | input | 32 | Window word written by the host |
| host_rdata | output | 32 | Window word read back by the host |

## Verification
The bench builds the bridge with LATENCY = 3 and BANK_DEPTH = 16. The short latency keeps the busy window small enough to inspect cycle by cycle, so a command can be injected in the middle of an access. The shallow bank leaves most of the 8-bit address range beyond its end, which makes the discard-and-zero behaviour for out-of-range addresses easy to reach.

// File: rtl/winbr_pkg.sv
package winbr_pkg;
   localparam int ADDR_W    = 8;
   localparam int BYTE_W    = 8;
   localparam int WORD_W    = 32;
   localparam int POS_ADDR  = 0;
   localparam int POS_WDATA = 8;
   localparam int POS_OP    = 16;
   localparam int POS_BUSY  = 23;
   localparam int POS_RDATA = 24;

   typedef struct packed {
      logic              is_wr;
      logic [BYTE_W-1:0] wdata;
      logic [ADDR_W-1:0] addr;
   } winbr_cmd_t;
endpackage

// File: rtl/winbr_sequencer.sv
module winbr_sequencer
   import winbr_pkg::*;
#(
   parameter int LATENCY = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       launch,
   input  winbr_cmd_t cmd_in,
   output winbr_cmd_t cmd_q,
   output logic       busy,
   output logic       done
);
   initial begin
      assert (LATENCY >= 1) else $error("LATENCY must be at least 1");
   end

   logic accept;
   assign accept = launch && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (accept) begin
         cmd_q <= cmd_in;
      end
   end

   generate
      if (LATENCY == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      busy <= 1'b0;
            else if (accept) busy <= 1'b1;
            else if (busy)   busy <= 1'b0;
         end
         assign done = busy;
      end else begin : g_count
         localparam int CNT_W = $clog2(LATENCY);
         localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy <= 1'b0;
               cnt  <= '0;
            end else if (accept) begin
               busy <= 1'b1;
               cnt  <= CNT_LOAD;
            end else if (busy) begin
               if (cnt == '0) busy <= 1'b0;
               else           cnt  <= cnt - 1'b1;
            end
         end
         assign done = busy && (cnt == '0);

         assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= CNT_LOAD);
      end
   endgenerate

   assert_busy_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && !busy) |=> busy);
   assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cmd_q));
endmodule

// File: rtl/winbr_bank.sv
module winbr_bank
   import winbr_pkg::*;
#(
   parameter int DEPTH = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata
);
   initial begin
      assert (DEPTH >= 1 && DEPTH <= (1 << ADDR_W))
         else $error("DEPTH must fit the address field");
   end

   logic [BYTE_W-1:0] regs [DEPTH];
   logic              in_range;
   assign in_range = ({1'b0, addr} < (ADDR_W+1)'(DEPTH));

   genvar gi;
   generate
      for (gi = 0; gi < DEPTH; gi++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               regs[gi] <= '0;
            else if (wr_en && in_range && (addr == ADDR_W'(gi)))
               regs[gi] <= wdata;
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (in_range && (addr == ADDR_W'(i))) rdata = regs[i];
      end
   end

   assert_bank_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_range) |=> (rdata == $past(wdata)) || (addr != $past(addr)));
endmodule

// File: rtl/winbr_bridge.sv
module winbr_bridge
   import winbr_pkg::*;
#(
   parameter int LATENCY    = 4,
   parameter int BANK_DEPTH = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_we,
   input  logic [31:0] host_wdata,
   output logic [31:0] host_rdata
);
   initial begin
      assert (WORD_W == 32) else $error("window word must be 32 bits");
   end

   winbr_cmd_t        cmd_in, cmd_q;
   logic              busy, done;
   logic [BYTE_W-1:0] bank_rdata, rd_q;
   logic              unused_host_bits;

   assign cmd_in.addr  = host_wdata[POS_ADDR  +: ADDR_W];
   assign cmd_in.wdata = host_wdata[POS_WDATA +: BYTE_W];
   assign cmd_in.is_wr = host_wdata[POS_OP];
   assign unused_host_bits = ^host_wdata[WORD_W-1:POS_OP+1];

   winbr_sequencer #(.LATENCY(LATENCY)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (host_we),
      .cmd_in (cmd_in),
      .cmd_q  (cmd_q),
      .busy   (busy),
      .done   (done)
   );

   winbr_bank #(.DEPTH(BANK_DEPTH)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (done && cmd_q.is_wr),
      .addr  (cmd_q.addr),
      .wdata (cmd_q.wdata),
      .rdata (bank_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   rd_q <= '0;
      else if (done && !cmd_q.is_wr) rd_q <= bank_rdata;
   end

   assign host_rdata = {rd_q, busy, 6'b0, cmd_q.is_wr, cmd_q.wdata, cmd_q.addr};

   assert_read_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !cmd_q.is_wr) |=> (host_rdata[POS_RDATA +: BYTE_W] == $past(bank_rdata)));
   assert_write_keeps_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cmd_q.is_wr) |=> $stable(rd_q));
endmodule

// File: tb/winbr_bridge_test.sv
module winbr_bridge_test;
   localparam int LAT   = 3;
   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   int          n_checks = 0;
   int          n_fail = 0;

   always #10 clk = ~clk;

   winbr_bridge #(.LATENCY(LAT), .BANK_DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we),
      .host_wdata(host_wdata), .host_rdata(host_rdata)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic [7:0] a, input logic [7:0] d,
                                      input bit wr);
      return {15'b0, wr, d, a};
   endfunction

   task automatic access(input logic [31:0] w, output int cyc, output bit seen);
      @(negedge clk);
      host_we = 1'b1;
      host_wdata = w;
      @(negedge clk);
      host_we = 1'b0;
      seen = host_rdata[23];
      cyc = 0;
      while (host_rdata[23] && cyc < 1000) begin
         cyc++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset;
      check(host_rdata == 32'h0, "R1", host_rdata, 32'h0);
   endtask

   task automatic t_fresh_read;
      int c; bit s;
      access(mk(8'h03, 8'h00, 1'b0), c, s);
      check(s, "R3", {31'b0, s}, 32'h1);
      check(c == LAT, "R4", c, LAT);
      check(host_rdata[31:24] == 8'h00, "R11", host_rdata[31:24], 8'h00);
   endtask

   task automatic t_write_layout;
      int c; bit s;
      access(mk(8'h05, 8'h3C, 1'b1), c, s);
      check(host_rdata[7:0] == 8'h05, "R2 addr", host_rdata[7:0], 8'h05);
      check(host_rdata[15:8] == 8'h3C, "R2 wdata", host_rdata[15:8], 8'h3C);
      check(host_rdata[16] == 1'b1, "R2 op", host_rdata[16], 1'b1);
      check(c == LAT, "R4 write", c, LAT);
   endtask

   task automatic t_read_timing;
      int c; bit ok;
      @(negedge clk);
      host_we = 1'b1;
      host_wdata = mk(8'h05, 8'h00, 1'b0);
      @(negedge clk);
      host_we = 1'b0;
      ok = 1'b1;
      c = 0;
      while (host_rdata[23] && c < 1000) begin
         if (host_rdata[31:24] != 8'h00) ok = 1'b0;
         c++;
         @(negedge clk);
      end
      check(ok, "R5 hold", {31'b0, ok}, 32'h1);
      check(host_rdata[31:24] == 8'h3C, "R5 update", host_rdata[31:24], 8'h3C);
      check(host_rdata[16] == 1'b0, "R2 read op", host_rdata[16], 1'b0);
   endtask

   task automatic t_write_then_read;
      int c; bit s;
      access(mk(8'h07, 8'h99, 1'b1), c, s);
      check(host_rdata[31:24] == 8'h3C, "R9", host_rdata[31:24], 8'h3C);
      access(mk(8'h07, 8'h00, 1'b0), c, s);
      check(host_rdata[31:24] == 8'h99, "R6", host_rdata[31:24], 8'h99);
   endtask

   task automatic t_ignore_busy;
      int c; bit s;
      @(negedge clk);
      host_we = 1'b1;
      host_wdata = mk(8'h05, 8'h00, 1'b0);
      @(negedge clk);
      host_wdata = mk(8'h07, 8'h11, 1'b1);
      @(negedge clk);
      host_we = 1'b0;
      check(host_rdata[16:0] == {1'b0, 8'h00, 8'h05}, "R7 fields",
            host_rdata[16:0], {15'b0, 17'h00005});
      c = 1;
      while (host_rdata[23] && c < 1000) begin
         c++;
         @(negedge clk);
      end
      check(c == LAT, "R7 timing", c, LAT);
      check(host_rdata[31:24] == 8'h3C, "R7 result", host_rdata[31:24], 8'h3C);
      access(mk(8'h07, 8'h00, 1'b0), c, s);
      check(host_rdata[31:24] == 8'h99, "R7 bank", host_rdata[31:24], 8'h99);
   endtask

   task automatic t_out_of_range;
      int c; bit s;
      access(mk(8'd20, 8'h77, 1'b1) | 32'h007E_0000, c, s);
      check(host_rdata[22:17] == 6'b0, "R8", host_rdata[22:17], 6'b0);
      access(mk(8'd20, 8'h00, 1'b0), c, s);
      check(host_rdata[31:24] == 8'h00, "R10 read", host_rdata[31:24], 8'h00);
      access(mk(8'd20 - 8'(DEPTH), 8'h00, 1'b0), c, s);
      check(host_rdata[31:24] == 8'h00, "R10 alias", host_rdata[31:24], 8'h00);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_fresh_read();
      t_write_layout();
      t_read_timing();
      t_write_then_read();
      t_ignore_busy();
      t_out_of_range();
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule